// File: doc/BRIEF.md
# NRZ Bit-Clock Recovery Phase/Frequency Detector

This block recovers timing from random NRZ data. It runs on the oscillator clock, which is nominally 128 times the bit rate. It divides that clock down to a bit clock and to a sample clock at 16 times the bit rate. An elapsed-time counter restarts on every transition of the incoming data. When it has run too long without a transition it stops and saturates.

The counter feeds two terms. A phase term is captured on each falling edge of the bit clock, as long as the counter has not saturated. A period term comes from the counter value at each restart. Each accepted period nudges a coarse frequency register up or down by one. The frequency register, weighted 64 times more heavily than a phase step, is summed with the held phase term. The sum forms a 16-bit control word for an external converter that steers the oscillator. A larger word is taken to raise the oscillator frequency. The word only moves when an accepted period measurement arrives, so the tuning voltage holds steady between updates.

Top module: `nrz_clock_recovery`

## Requirements
- R1: After reset release the bit clock runs at the oscillator rate divided by 128. It is low for the first 64 cycles of each 128-cycle period and high for the last 64, starting low on the first counting edge.
- R2: The sample clock has a period of 8 oscillator cycles and is low for the first 4 of them. It is low whenever the bit clock falls.
- R3: While reset is applied, and for two edges after its release, the phase output is 0, the control word is 32768, and both clocks are low.
- R4: A level change of the data input is detected on the third rising edge after it, whichever way it goes. On that edge the elapsed counter restarts at 0, and it rises by one on each later edge. On a falling bit-clock edge the phase output takes the counter value from just before that edge.
- R5: The elapsed counter stops at 192. A falling bit-clock edge that finds it at 192 leaves the phase output unchanged.
- R6: At each detected transition the measured period is the counter value plus one, which equals the spacing in cycles between the two transitions. It is accepted only if the counter was below 192. The first transition after reset is never accepted.
- R7: For an accepted period below 128 the frequency register steps up by one. Above 128 it steps down by one. At exactly 128 it stays. The register starts at 512.
- R8: On the edge of an accepted period the control word becomes frequency register times 64 plus the phase output held before that edge. Otherwise the word holds.
- R9: The frequency register saturates at 0 and at 32767 instead of wrapping.
- R10: A control-word sum above 65535 is clamped to 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco_i | input | 1 | Oscillator clock, 128 times the bit rate |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_i | input | 1 | Thresholded NRZ data, asynchronous to the clock |
| bit_clk_o | output | 1 | Recovered bit clock, oscillator divided by 128 |
| samp_clk_o | output | 1 | Sample clock, oscillator divided by 8 |
| phase_o | output | 8 | Held phase term, counter value at the last valid bit-clock fall |
| dac_word_o | output | 16 | Control word for the oscillator-tuning converter |

## Verification
A divider slip moves every bit-clock and sample-clock edge, so it shows within one bit period. It also shifts the phase values captured afterwards. A corrupted elapsed counter first shows at the next falling bit-clock edge as a wrong phase value, at most 128 cycles later. A wrong saturation limit shows as a phase update that should have been suppressed after a long idle run.

The frequency register is not visible directly. A fault in it appears in the control word at the next accepted transition, as a step of the wrong sign or size. Sustained runs of short and long spacings drive it into its floor and into the word clamp.

// File: rtl/ncr_pkg.sv
package ncr_pkg;

  // Direction of one coarse frequency correction
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  localparam int unsigned BIT_DIV_DEF   = 128;
  localparam int unsigned SAMP_DIV_DEF  = 8;
  localparam int unsigned SAT_DEF       = 192;
  localparam int unsigned PHASE_W_DEF   = 8;
  localparam int unsigned FREQ_W_DEF    = 15;
  localparam int unsigned DAC_W_DEF     = 16;
  localparam int unsigned WEIGHT_DEF    = 64;
  localparam int unsigned FREQ_INIT_DEF = 512;

endpackage

// File: rtl/ncr_input_sync.sv
// Reset release synchroniser and data-transition detector.
module ncr_input_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  input  logic data_i,
  output logic rst_n_s,
  output logic edge_o
);

  logic [1:0]           rst_q;
  logic [SYNC_STAGES:0] pipe_q;
  logic [SYNC_STAGES:0] pipe_nxt;

  // reset asserts at once, releases after two edges
  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) rst_q <= '0;
    else          rst_q <= {rst_q[0], 1'b1};
  end

  assign rst_n_s = rst_q[1];

  always_comb begin
    pipe_nxt = {pipe_q[SYNC_STAGES-1:0], data_i};
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) pipe_q <= '0;
    else          pipe_q <= pipe_nxt;
  end

  // a change between the two newest synchronised samples
  assign edge_o = pipe_q[SYNC_STAGES] ^ pipe_q[SYNC_STAGES-1];

endmodule

// File: rtl/ncr_divider.sv
// Free-running divider producing the bit clock and the sample clock.
// Both ratios must be powers of two, SAMP_DIV below BIT_DIV.
module ncr_divider #(
  parameter int unsigned BIT_DIV  = 128,
  parameter int unsigned SAMP_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic bit_clk_o,
  output logic samp_clk_o,
  output logic fall_o
);

  localparam int unsigned CW = $clog2(BIT_DIV);
  localparam int unsigned SW = $clog2(SAMP_DIV);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign bit_clk_o  = cnt_q[CW-1];
  assign samp_clk_o = cnt_q[SW-1];
  // the edge that wraps the count is the bit clock's falling edge
  assign fall_o     = (cnt_q == CW'(BIT_DIV - 1));

endmodule

// File: rtl/ncr_period_meter.sv
// Elapsed-time counter: restarts on transitions, saturates, yields the
// phase sample and the period measurement.
module ncr_period_meter #(
  parameter int unsigned SAT     = 192,
  parameter int unsigned PHASE_W = 8,
  localparam int unsigned CW     = $clog2(SAT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               edge_i,
  input  logic               fall_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               meas_valid_o,
  output logic [CW-1:0]      period_o
);

  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  logic [CW-1:0]      cnt_q, cnt_nxt;
  logic [PHASE_W-1:0] phase_q;
  logic               sat_w;
  logic               phase_en;

  assign sat_w = (cnt_q == SAT_V);

  always_comb begin
    if (edge_i)     cnt_nxt = '0;
    else if (sat_w) cnt_nxt = SAT_V;
    else            cnt_nxt = cnt_q + CW'(1);
  end

  assign phase_en = fall_i && !sat_w;

  // starts saturated so that the first transition measures nothing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= SAT_V;
    else        cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_en) phase_q <= PHASE_W'(cnt_q);
  end

  assign phase_o      = phase_q;
  assign meas_valid_o = edge_i && !sat_w;
  assign period_o     = cnt_q + CW'(1);

endmodule

// File: rtl/ncr_freq_loop.sv
// Coarse frequency register and the weighted control-word adder.
module ncr_freq_loop
  import ncr_pkg::*;
#(
  parameter int unsigned PERIOD_W  = 8,
  parameter int unsigned PHASE_W   = 8,
  parameter int unsigned FREQ_W    = 15,
  parameter int unsigned DAC_W     = 16,
  parameter int unsigned NOMINAL   = 128,
  parameter int unsigned WEIGHT    = 64,
  parameter int unsigned FREQ_INIT = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                meas_valid_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [PHASE_W-1:0]  phase_i,
  output logic [DAC_W-1:0]    dac_o
);

  localparam int unsigned WSH   = $clog2(WEIGHT);
  localparam int unsigned SUM_W = FREQ_W + WSH + 1;
  localparam logic [FREQ_W-1:0] FREQ_MAX = '1;
  localparam logic [DAC_W-1:0]  DAC_MAX  = '1;
  localparam longint unsigned   INIT_SUM = longint'(FREQ_INIT) * longint'(WEIGHT);
  localparam longint unsigned   DAC_MAXL = (longint'(1) << DAC_W) - 1;
  localparam logic [DAC_W-1:0]  DAC_INIT = (INIT_SUM > DAC_MAXL) ? DAC_MAX : DAC_W'(INIT_SUM);

  step_e              step;
  logic [FREQ_W-1:0]  freq_q, freq_nxt;
  logic [SUM_W-1:0]   sum;
  logic [DAC_W-1:0]   dac_q, dac_nxt;

  always_comb begin
    step = STEP_HOLD;
    if (meas_valid_i) begin
      if (period_i < PERIOD_W'(NOMINAL))      step = STEP_UP;
      else if (period_i > PERIOD_W'(NOMINAL)) step = STEP_DOWN;
    end
  end

  always_comb begin
    freq_nxt = freq_q;
    case (step)
      STEP_UP:   if (freq_q != FREQ_MAX) freq_nxt = freq_q + FREQ_W'(1);
      STEP_DOWN: if (freq_q != '0)       freq_nxt = freq_q - FREQ_W'(1);
      default:   freq_nxt = freq_q;
    endcase
  end

  always_comb begin
    sum     = (SUM_W'(freq_nxt) << WSH) + SUM_W'(phase_i);
    dac_nxt = (sum > SUM_W'(DAC_MAX)) ? DAC_MAX : sum[DAC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= FREQ_W'(FREQ_INIT);
      dac_q  <= DAC_INIT;
    end else if (meas_valid_i) begin
      freq_q <= freq_nxt;
      dac_q  <= dac_nxt;
    end
  end

  assign dac_o = dac_q;

endmodule

// File: rtl/nrz_clock_recovery.sv
module nrz_clock_recovery
  import ncr_pkg::*;
#(
  parameter int unsigned BIT_DIV   = BIT_DIV_DEF,
  parameter int unsigned SAMP_DIV  = SAMP_DIV_DEF,
  parameter int unsigned SAT       = SAT_DEF,
  parameter int unsigned PHASE_W   = PHASE_W_DEF,
  parameter int unsigned FREQ_W    = FREQ_W_DEF,
  parameter int unsigned DAC_W     = DAC_W_DEF,
  parameter int unsigned WEIGHT    = WEIGHT_DEF,
  parameter int unsigned FREQ_INIT = FREQ_INIT_DEF
) (
  input  logic               clk_vco_i,
  input  logic               rst_n_i,
  input  logic               data_i,
  output logic               bit_clk_o,
  output logic               samp_clk_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic [DAC_W-1:0]   dac_word_o
);

  localparam int unsigned PERIOD_W = $clog2(SAT + 1);

  logic                rst_n_s;
  logic                edge_det;
  logic                fall_evt;
  logic                meas_valid;
  logic [PERIOD_W-1:0] period;

  ncr_input_sync #(.SYNC_STAGES(2)) u_sync (
    .clk     (clk_vco_i),
    .rst_n_a (rst_n_i),
    .data_i  (data_i),
    .rst_n_s (rst_n_s),
    .edge_o  (edge_det)
  );

  ncr_divider #(.BIT_DIV(BIT_DIV), .SAMP_DIV(SAMP_DIV)) u_div (
    .clk        (clk_vco_i),
    .rst_n      (rst_n_s),
    .bit_clk_o  (bit_clk_o),
    .samp_clk_o (samp_clk_o),
    .fall_o     (fall_evt)
  );

  ncr_period_meter #(.SAT(SAT), .PHASE_W(PHASE_W)) u_meter (
    .clk          (clk_vco_i),
    .rst_n        (rst_n_s),
    .edge_i       (edge_det),
    .fall_i       (fall_evt),
    .phase_o      (phase_o),
    .meas_valid_o (meas_valid),
    .period_o     (period)
  );

  ncr_freq_loop #(
    .PERIOD_W (PERIOD_W),
    .PHASE_W  (PHASE_W),
    .FREQ_W   (FREQ_W),
    .DAC_W    (DAC_W),
    .NOMINAL  (BIT_DIV),
    .WEIGHT   (WEIGHT),
    .FREQ_INIT(FREQ_INIT)
  ) u_freq (
    .clk          (clk_vco_i),
    .rst_n        (rst_n_s),
    .meas_valid_i (meas_valid),
    .period_i     (period),
    .phase_i      (phase_o),
    .dac_o        (dac_word_o)
  );

endmodule

// File: rtl/ncr_checker.sv
module ncr_checker #(
  parameter int unsigned PHASE_W = 8,
  parameter int unsigned DAC_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               edge_det,
  input logic               fall_evt,
  input logic               meas_valid,
  input logic               bit_clk,
  input logic               samp_clk,
  input logic [PHASE_W-1:0] phase,
  input logic [DAC_W-1:0]   dac_word
);

  // R1: the divider's wrap event leaves the bit clock low
  p_fall_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !bit_clk);

  // R2: sample clock is low whenever the bit clock has just fallen
  p_samp_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bit_clk) |-> !samp_clk);

  // R4: phase output changes only on a bit-clock fall
  p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(phase));

  // R6: a measurement needs a detected transition
  p_meas_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |-> edge_det);

  // R6: nothing is measured on the first cycle out of reset
  p_no_meas_at_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !meas_valid);

  // R8: control word holds between accepted measurements
  p_dac_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid |=> $stable(dac_word));

endmodule

bind nrz_clock_recovery ncr_checker #(.PHASE_W(PHASE_W), .DAC_W(DAC_W)) u_chk (
  .clk        (clk_vco_i),
  .rst_n      (rst_n_s),
  .edge_det   (edge_det),
  .fall_evt   (fall_evt),
  .meas_valid (meas_valid),
  .bit_clk    (bit_clk_o),
  .samp_clk   (samp_clk_o),
  .phase      (phase_o),
  .dac_word   (dac_word_o)
);

// File: tb/test_nrz_clock_recovery.sv
module test_nrz_clock_recovery;

  localparam int SAT      = 192;
  localparam int NOM      = 128;
  localparam int F_INIT   = 512;
  localparam int F_MAX    = 32767;
  localparam int DAC_INIT = 32768;
  localparam int DAC_MAX  = 65535;
  localparam int NUM_VEC  = 16;
  // gaps between successive data toggles, in clock cycles
  localparam int GAP_TAB [NUM_VEC] = '{200, 128, 128, 100, 150, 128, 192, 193,
                                       60, 128, 40, 300, 64, 127, 129, 50};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       data;
  logic       bit_clk, samp_clk;
  logic [7:0] phase;
  logic [15:0] dac;

  always #5 clk = ~clk;

  nrz_clock_recovery i_nrz_clock_recovery (
    .clk_vco_i  (clk),
    .rst_n_i    (rst_n),
    .data_i     (data),
    .bit_clk_o  (bit_clk),
    .samp_clk_o (samp_clk),
    .phase_o    (phase),
    .dac_word_o (dac)
  );

  int  cyc = 0, rel_cyc = 0, last_x = 0, pend_x = 0;
  bit  started = 0, have_x = 0, pend = 0, done = 0;
  int  f_m, exp_phase, exp_dac;
  int  checks = 0, fails = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model();
    int k, d, old_phase, n;
    if (!started || cyc < rel_cyc + 2) begin
      check(phase == 8'd0, "R3 phase", int'(phase), 0);
      check(dac == 16'(DAC_INIT), "R3 dac", int'(dac), DAC_INIT);
      check(bit_clk == 1'b0 && samp_clk == 1'b0, "R3 clocks", int'({bit_clk, samp_clk}), 0);
      return;
    end
    k = cyc - rel_cyc - 2;
    d = k % 128;
    old_phase = exp_phase;
    if (d == 0 && k > 0 && have_x && (cyc - 1 - last_x) < SAT)
      exp_phase = cyc - 1 - last_x;
    if (pend && pend_x == cyc) begin
      if (have_x && (cyc - 1 - last_x) < SAT) begin
        n = cyc - last_x;
        if (n < NOM && f_m < F_MAX) f_m++;
        else if (n > NOM && f_m > 0) f_m--;
        exp_dac = f_m * 64 + old_phase;
        if (exp_dac > DAC_MAX) exp_dac = DAC_MAX;
      end
      last_x = cyc;
      have_x = 1;
      pend   = 0;
    end
    check(bit_clk == (d >= 64), "R1 bit clock", int'(bit_clk), int'(d >= 64));
    check(samp_clk == ((d >> 2) & 1), "R2 sample clock", int'(samp_clk), (d >> 2) & 1);
    check(int'(phase) == exp_phase, "R4/R5 phase", int'(phase), exp_phase);
    check(int'(dac) == exp_dac, "R7/R8 dac word", int'(dac), exp_dac);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      model();
    end
  endtask

  task automatic toggle();
    data   = ~data;
    pend_x = cyc + 3;
    pend   = 1;
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    data      = 1'b0;
    started   = 0;
    have_x    = 0;
    pend      = 0;
    f_m       = F_INIT;
    exp_phase = 0;
    exp_dac   = DAC_INIT;
    tick(3);
    rst_n   = 1'b1;
    rel_cyc = cyc;
    started = 1;
    tick(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    int held;
    rst_n = 1'b0;
    data  = 1'b0;
    @(negedge clk);
    do_reset();

    // R6: first transition after reset is not a measurement
    tick(10);
    toggle();
    tick(10);
    check(dac == 16'(DAC_INIT), "R6 first transition ignored", int'(dac), DAC_INIT);

    // table walk: mixed spacings, both polarities (R4, R6, R7, R8)
    for (int v = 0; v < NUM_VEC; v++) begin
      tick(GAP_TAB[v]);
      toggle();
    end
    tick(10);

    // R5: saturated counter leaves phase unchanged over later bit-clock falls
    toggle();
    tick(250);
    held = int'(phase);
    tick(300);
    check(int'(phase) == held, "R5 phase held after saturation", int'(phase), held);

    // R3: reset in mid-run
    @(negedge clk);
    do_reset();
    check(dac == 16'(DAC_INIT) && phase == 8'd0, "R3 state after reset",
          int'(dac), DAC_INIT);

    // R10: many short periods push the sum past the clamp
    for (int i = 0; i < 600; i++) begin
      tick(4);
      toggle();
    end
    tick(6);
    check(dac == 16'(DAC_MAX), "R10 clamp", int'(dac), DAC_MAX);

    // R9: many long periods drive the frequency register to its floor
    do_reset();
    for (int i = 0; i < 520; i++) begin
      tick(140);
      toggle();
    end
    tick(6);
    check(f_m == 0 && int'(dac) == exp_dac && dac < 16'd64, "R9 floor at zero",
          int'(dac), exp_dac);

    finish_run();
  end

endmodule